// File: doc/BRIEF.md
# Converter Interrupt Flag Register

This block holds the interrupt status of a data converter's digital control section. It presents six sticky flags as one 8-bit register on a simple register bus. The conversion engine sends single-cycle strobes: a start trigger together with a busy level, a new-sample strobe, a new-result strobe (conversion or accumulation complete) and a window-match level. The block turns these strobes into flags and combines the flags with an enable mask into one level-sensitive interrupt line.

Two data registers, sample and result, live outside this block. The block watches bus reads at their addresses for two reasons. A read of a data register clears the matching ready flag. A read also marks that data as consumed. The block keeps a private "unread" bit for each data register, and it raises an overwrite flag when new data arrives while the previous value is still unread. Software clears any flag by writing a 1 to its bit.

Top module: `cif_flag_reg`

## Requirements
- R1: After reset every flag is 0 and the interrupt is low. Reading the flag register at address 0x05 returns bits 7:6 as 0 at all times.
- R2: A bus write to address 0x05 clears each flag whose write-data bit is 1. A data bit of 0 leaves the flag unchanged. Bit layout: 5 trigger overrun, 4 sample overwrite, 3 result overwrite, 2 window match, 1 sample ready, 0 result ready.
- R3: Bit 5 sets when a start trigger arrives while the busy input is high. A trigger while not busy leaves bit 5 unchanged.
- R4: Bit 1 sets on the new-sample strobe. A bus read at the sample address 0x0C clears it.
- R5: Bit 0 sets on the new-result strobe. A bus read at the result address 0x0E clears it.
- R6: Bit 2 sets only on a new-result strobe that coincides with an asserted window-match input.
- R7: Bit 4 (or bit 3) sets when a new-sample (or new-result) strobe arrives while the previous sample (or result) has not been read. A data read in the same cycle as the strobe consumes the old value, so no overwrite is flagged.
- R8: Clearing a ready flag with a write to 0x05 does not mark its data as read. The next strobe still flags an overwrite.
- R9: When a set event and a clear (a write of 1 or a data read) hit the same flag in the same cycle, the flag ends up 1.
- R10: The irq output equals the OR over all bits of (flags AND irq_en), with bits 7:6 of the flags taken as 0. It follows the flags in the same cycle.
- R11: Read data is registered. It appears in the cycle after a read strobe and holds the flag value from before that edge. Reads at any other address return 0. Writes to other addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read side effects happen only with it |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| start_trig | input | 1 | Start-of-conversion trigger strobe |
| conv_busy | input | 1 | High while a conversion is in progress |
| sample_done | input | 1 | New sample strobe |
| result_done | input | 1 | New result strobe (conversion or accumulation complete) |
| win_match | input | 1 | Window comparator match, valid with result_done |
| irq_en | input | 8 | Interrupt enable mask |
| irq | output | 1 | Combined interrupt level |

## Verification
The properties assume that the engine strobes last one cycle each. They also assume that win_match matters only in a cycle with result_done, and that inputs hold a known value from the first clock while reset is asserted. The bench drives every input from the falling edge and holds all of them at 0 during reset. It uses the same three addresses, plus one unused address, for every bus access, so each property sees only legal address, strobe and busy combinations. This holds in the directed steps and in the pseudo-random sweep.

// File: rtl/cif_pkg.sv
package cif_pkg;
   localparam int FLAG_COUNT = 6;

   // Flag bit positions; software decodes these, so they are fixed.
   localparam int B_RES_RDY = 0;
   localparam int B_SMP_RDY = 1;
   localparam int B_WIN     = 2;
   localparam int B_RES_OVW = 3;
   localparam int B_SMP_OVW = 4;
   localparam int B_TRG_OVR = 5;

   typedef enum logic [1:0] {
      ACC_NONE   = 2'd0,
      ACC_FLAGS  = 2'd1,
      ACC_SAMPLE = 2'd2,
      ACC_RESULT = 2'd3
   } acc_kind_e;

   typedef struct packed {
      logic trg_ovr;
      logic smp_ovw;
      logic res_ovw;
      logic win;
      logic smp_rdy;
      logic res_rdy;
   } flag_vec_t;
endpackage

// File: rtl/cif_bus_decode.sv
module cif_bus_decode
   import cif_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter int NF          = FLAG_COUNT,
   parameter int FLAG_ADDR   = 5,
   parameter int SAMPLE_ADDR = 12,
   parameter int RESULT_ADDR = 14
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [NF-1:0]     wdata_lo,
   output logic [NF-1:0]     w1c_mask,
   output logic              flag_read,
   output logic              smp_read,
   output logic              res_read
);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);
   localparam logic [ADDR_W-1:0] A_SMP  = ADDR_W'(SAMPLE_ADDR);
   localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(RESULT_ADDR);

   acc_kind_e kind;

   always_comb begin
      if (addr == A_FLAG)
         kind = ACC_FLAGS;
      else if (addr == A_SMP)
         kind = ACC_SAMPLE;
      else if (addr == A_RES)
         kind = ACC_RESULT;
      else
         kind = ACC_NONE;
   end

   always_comb begin
      w1c_mask  = (wr && kind == ACC_FLAGS) ? wdata_lo : '0;
      flag_read = rd && (kind == ACC_FLAGS);
      smp_read  = rd && (kind == ACC_SAMPLE);
      res_read  = rd && (kind == ACC_RESULT);
   end
endmodule

// File: rtl/cif_unread.sv
module cif_unread (
   input  logic clk,
   input  logic rst_n,
   input  logic new_data,
   input  logic data_read,
   output logic overwrite
);
   logic pending_q;

   // A read in the same cycle as a strobe consumes the old value.
   assign overwrite = new_data && pending_q && !data_read;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pending_q <= 1'b0;
      else if (new_data)
         pending_q <= 1'b1;
      else if (data_read)
         pending_q <= 1'b0;
   end
endmodule

// File: rtl/cif_flag_bank.sv
module cif_flag_bank #(
   parameter int NF = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set_ev,
   input  logic [NF-1:0] clr_ev,
   output logic [NF-1:0] flags
);
   for (genvar i = 0; i < NF; i++) begin : g_cell
      logic cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= 1'b0;
         else if (set_ev[i])
            cell_q <= 1'b1;
         else if (clr_ev[i])
            cell_q <= 1'b0;
      end
      assign flags[i] = cell_q;
   end
endmodule

// File: rtl/cif_irq_out.sv
module cif_irq_out #(
   parameter int NF         = 6,
   parameter int DATA_W     = 8,
   parameter bit REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NF-1:0]     flags,
   input  logic [DATA_W-1:0] enable,
   output logic              irq
);
   logic [DATA_W-1:0] wide;
   logic              any;

   assign wide = DATA_W'(flags);
   assign any  = |(wide & enable);

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            irq_q <= 1'b0;
         else
            irq_q <= any;
      end
      assign irq = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq = any;
   end
endmodule

// File: rtl/cif_flag_reg.sv
module cif_flag_reg
   import cif_pkg::*;
#(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter int FLAG_ADDR    = 5,
   parameter int SAMPLE_ADDR  = 12,
   parameter int RESULT_ADDR  = 14,
   parameter bit IRQ_REGISTER = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              start_trig,
   input  logic              conv_busy,
   input  logic              sample_done,
   input  logic              result_done,
   input  logic              win_match,
   input  logic [DATA_W-1:0] irq_en,
   output logic              irq
);
   localparam int NF  = FLAG_COUNT;
   localparam int PAD = DATA_W - NF;

   if (DATA_W < NF) begin : g_chk_width
      $error("DATA_W must hold all flag bits");
   end
   if (FLAG_ADDR == SAMPLE_ADDR || FLAG_ADDR == RESULT_ADDR ||
       SAMPLE_ADDR == RESULT_ADDR) begin : g_chk_addr
      $error("register addresses must be distinct");
   end
   if (FLAG_ADDR >= (1 << ADDR_W) || SAMPLE_ADDR >= (1 << ADDR_W) ||
       RESULT_ADDR >= (1 << ADDR_W)) begin : g_chk_range
      $error("register address outside ADDR_W");
   end

   logic [NF-1:0] w1c_mask;
   logic          flag_read, smp_read, res_read;
   logic          smp_ovw, res_ovw;
   logic [NF-1:0] set_ev, clr_ev, flags;
   logic [DATA_W-1:0] rdata_q;

   if (PAD > 0) begin : g_hi
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NF];
   end

   cif_bus_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NF(NF),
      .FLAG_ADDR(FLAG_ADDR), .SAMPLE_ADDR(SAMPLE_ADDR), .RESULT_ADDR(RESULT_ADDR)
   ) u_dec (
      .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .wdata_lo(bus_wdata[NF-1:0]),
      .w1c_mask(w1c_mask), .flag_read(flag_read),
      .smp_read(smp_read), .res_read(res_read)
   );

   cif_unread u_smp_track (
      .clk(clk), .rst_n(rst_n), .new_data(sample_done),
      .data_read(smp_read), .overwrite(smp_ovw)
   );

   cif_unread u_res_track (
      .clk(clk), .rst_n(rst_n), .new_data(result_done),
      .data_read(res_read), .overwrite(res_ovw)
   );

   always_comb begin
      set_ev            = '0;
      set_ev[B_TRG_OVR] = start_trig && conv_busy;
      set_ev[B_SMP_OVW] = smp_ovw;
      set_ev[B_RES_OVW] = res_ovw;
      set_ev[B_WIN]     = result_done && win_match;
      set_ev[B_SMP_RDY] = sample_done;
      set_ev[B_RES_RDY] = result_done;

      clr_ev            = w1c_mask;
      clr_ev[B_SMP_RDY] = w1c_mask[B_SMP_RDY] || smp_read;
      clr_ev[B_RES_RDY] = w1c_mask[B_RES_RDY] || res_read;
   end

   cif_flag_bank #(.NF(NF)) u_bank (
      .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_ev(clr_ev), .flags(flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (flag_read)
         rdata_q <= DATA_W'(flags);
      else
         rdata_q <= '0;
   end
   assign bus_rdata = rdata_q;

   cif_irq_out #(.NF(NF), .DATA_W(DATA_W), .REGISTERED(IRQ_REGISTER)) u_irq (
      .clk(clk), .rst_n(rst_n), .flags(flags), .enable(irq_en), .irq(irq)
   );
endmodule

// File: rtl/cif_flag_reg_chk.sv
module cif_flag_reg_chk #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int NF        = 6,
   parameter int FLAG_ADDR = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              start_trig,
   input logic              conv_busy,
   input logic              sample_done,
   input logic              result_done,
   input logic              win_match,
   input logic [NF-1:0]     flags
);
   localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(FLAG_ADDR);

   if (DATA_W > NF) begin : g_pad
      assert_pad_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
         bus_rdata[DATA_W-1:NF] == '0);
   end

   assert_w1c_trg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && bus_addr == A_FLAG && bus_wdata[5] && !(start_trig && conv_busy)
      |=> !flags[5]);

   assert_trig_ovr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_trig && conv_busy |=> flags[5]);

   assert_smp_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sample_done |=> flags[1]);

   assert_res_rdy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      result_done |=> flags[0]);

   assert_win_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[2]) |-> $past(result_done && win_match));

   assert_smp_ovw_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[4]) |-> $past(sample_done));

   assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr && !bus_rd && !start_trig && !sample_done && !result_done
      |=> $stable(flags));

   assert_foreign_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && bus_addr == A_FLAG) |=> bus_rdata == '0);
endmodule

bind cif_flag_reg cif_flag_reg_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NF(NF), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .start_trig(start_trig), .conv_busy(conv_busy), .sample_done(sample_done),
   .result_done(result_done), .win_match(win_match), .flags(flags)
);

// File: tb/test_cif_flag_reg.sv
`timescale 1ns/1ps
module test_cif_flag_reg;
   localparam logic [7:0] A_FLAG = 8'h05;
   localparam logic [7:0] A_SMP  = 8'h0C;
   localparam logic [7:0] A_RES  = 8'h0E;
   localparam logic [7:0] A_OTH  = 8'h33;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       start_trig = 1'b0, conv_busy = 1'b0;
   logic       sample_done = 1'b0, result_done = 1'b0, win_match = 1'b0;
   logic [7:0] irq_en = '0;
   logic       irq;

   int checks = 0, fails = 0;
   logic [5:0] m_flags = '0;
   logic       m_su = 1'b0, m_ru = 1'b0;
   logic [7:0] m_rdata = '0;

   always #2.5 clk = ~clk;

   cif_flag_reg i_cif_flag_reg (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .start_trig(start_trig), .conv_busy(conv_busy), .sample_done(sample_done),
      .result_done(result_done), .win_match(win_match), .irq_en(irq_en), .irq(irq)
   );

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic drive(logic [7:0] a, logic w, logic r, logic [7:0] d,
                        logic trg, logic bsy, logic sd, logic rd_, logic win);
      bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
      start_trig = trg; conv_busy = bsy; sample_done = sd;
      result_done = rd_; win_match = win;
   endtask

   // Reference model built from the requirements; advances one clock.
   task automatic tick(string req);
      logic [5:0] set, clr;
      logic srd, rrd;
      srd = bus_rd && bus_addr == A_SMP;
      rrd = bus_rd && bus_addr == A_RES;
      set = {start_trig && conv_busy, sample_done && m_su && !srd,
             result_done && m_ru && !rrd, result_done && win_match,
             sample_done, result_done};
      clr = (bus_wr && bus_addr == A_FLAG) ? bus_wdata[5:0] : 6'd0;
      clr[1] = clr[1] | srd;
      clr[0] = clr[0] | rrd;
      m_rdata = (bus_rd && bus_addr == A_FLAG) ? {2'b00, m_flags} : 8'h00;
      @(posedge clk);
      m_flags = set | (m_flags & ~clr);
      m_su = sample_done ? 1'b1 : (srd ? 1'b0 : m_su);
      m_ru = result_done ? 1'b1 : (rrd ? 1'b0 : m_ru);
      @(negedge clk);
      check({req, " rdata (R11)"}, bus_rdata, m_rdata);
      check({req, " irq (R10)"}, {7'd0, irq}, {7'd0, |(irq_en & {2'b00, m_flags})});
      drive(A_OTH, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic read_flags(string req, logic [7:0] exp);
      drive(A_FLAG, 0, 1, 0, 0, 0, 0, 0, 0);
      tick(req);
      check(req, bus_rdata, exp);
   endtask

   task automatic step(string req, logic [7:0] a, logic w, logic r, logic [7:0] d,
                       logic trg, logic bsy, logic sd, logic rd_, logic win);
      drive(a, w, r, d, trg, bsy, sd, rd_, win);
      tick(req);
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(negedge clk);
      check("R1 irq after reset", {7'd0, irq}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      read_flags("R1 reset value", 8'h00);

      // R4 sample ready
      step("R4 set", A_OTH, 0, 0, 0, 0, 0, 1, 0, 0);
      read_flags("R4 sample ready set", 8'h02);
      step("R4 clr", A_SMP, 0, 1, 0, 0, 0, 0, 0, 0);
      read_flags("R4 cleared by sample read", 8'h00);

      // R5 result ready
      step("R5 set", A_OTH, 0, 0, 0, 0, 0, 0, 1, 0);
      read_flags("R5 result ready set", 8'h01);
      step("R5 clr", A_RES, 0, 1, 0, 0, 0, 0, 0, 0);
      read_flags("R5 cleared by result read", 8'h00);

      // R6 window match only with result strobe
      step("R6 lone match", A_OTH, 0, 0, 0, 0, 0, 0, 0, 1);
      read_flags("R6 match without result", 8'h00);
      step("R6 set", A_OTH, 0, 0, 0, 0, 0, 0, 1, 1);
      read_flags("R6 window flag set", 8'h05);
      step("R6 rd", A_RES, 0, 1, 0, 0, 0, 0, 0, 0);
      step("R6 w1c", A_FLAG, 1, 0, 8'h04, 0, 0, 0, 0, 0);
      read_flags("R6 window flag cleared", 8'h00);

      // R3 trigger overrun, R2 write semantics
      step("R3 idle", A_OTH, 0, 0, 0, 1, 0, 0, 0, 0);
      read_flags("R3 trigger while idle", 8'h00);
      step("R3 busy", A_OTH, 0, 0, 0, 1, 1, 0, 0, 0);
      read_flags("R3 trigger while busy", 8'h20);
      step("R2 zero", A_FLAG, 1, 0, 8'h00, 0, 0, 0, 0, 0);
      read_flags("R2 write of zeros", 8'h20);
      step("R2 other", A_FLAG, 1, 0, 8'hDF, 0, 0, 0, 0, 0);
      read_flags("R2 other bits set", 8'h20);
      step("R11 foreign", A_OTH, 1, 0, 8'hFF, 0, 0, 0, 0, 0);
      read_flags("R11 write elsewhere", 8'h20);
      step("R2 clr", A_FLAG, 1, 0, 8'h20, 0, 0, 0, 0, 0);
      read_flags("R2 bit 5 cleared", 8'h00);

      // R7 sample overwrite and same-cycle read
      step("R7 s1", A_OTH, 0, 0, 0, 0, 0, 1, 0, 0);
      step("R7 s2", A_OTH, 0, 0, 0, 0, 0, 1, 0, 0);
      read_flags("R7 sample overwrite", 8'h12);
      step("R7 w1c", A_FLAG, 1, 0, 8'h12, 0, 0, 0, 0, 0);
      step("R7 rd", A_SMP, 0, 1, 0, 0, 0, 0, 0, 0);
      step("R7 s3", A_OTH, 0, 0, 0, 0, 0, 1, 0, 0);
      step("R7 R9 s4+rd", A_SMP, 0, 1, 0, 0, 0, 1, 0, 0);
      read_flags("R7 R9 read with strobe: no overwrite, set wins", 8'h02);
      step("R7 rd2", A_SMP, 0, 1, 0, 0, 0, 0, 0, 0);
      read_flags("R7 clean", 8'h00);

      // R8 W1C does not consume data
      step("R8 r1", A_OTH, 0, 0, 0, 0, 0, 0, 1, 0);
      step("R8 w1c", A_FLAG, 1, 0, 8'h01, 0, 0, 0, 0, 0);
      read_flags("R8 ready cleared by write", 8'h00);
      step("R8 r2", A_OTH, 0, 0, 0, 0, 0, 0, 1, 0);
      read_flags("R8 overwrite still seen", 8'h09);
      step("R8 rd", A_RES, 0, 1, 0, 0, 0, 0, 0, 0);
      step("R8 w1c all", A_FLAG, 1, 0, 8'h3F, 0, 0, 0, 0, 0);
      read_flags("R8 clean", 8'h00);

      // R9 set beats W1C
      step("R9", A_FLAG, 1, 0, 8'h3F, 1, 1, 0, 1, 0);
      read_flags("R9 set wins over write", 8'h21);
      step("R9 rd", A_RES, 0, 1, 0, 0, 0, 0, 0, 0);
      step("R9 w1c", A_FLAG, 1, 0, 8'h3F, 0, 0, 0, 0, 0);

      // R10 full enable sweep over flags 0x27
      step("R10 prep", A_OTH, 0, 0, 0, 1, 1, 1, 1, 1);
      for (int e = 0; e < 256; e++) begin
         irq_en = 8'(e);
         #1;
         check("R10 enable sweep", {7'd0, irq}, {7'd0, ((e & 8'h27) != 0)});
      end
      irq_en = 8'hFF;

      // R2 all 64 clear masks over a full flag set
      for (int m = 0; m < 64; m++) begin
         step("R2 fill a", A_OTH, 0, 0, 0, 1, 1, 1, 1, 1);
         step("R2 fill b", A_OTH, 0, 0, 0, 0, 0, 1, 1, 0);
         step("R2 mask", A_FLAG, 1, 0, 8'(m), 0, 0, 0, 0, 0);
         read_flags("R2 mask sweep", 8'h3F & ~8'(m));
      end

      // Pseudo-random sweep against the model
      lfsr = 32'hACE1_2357;
      for (int n = 0; n < 4000; n++) begin
         logic [7:0] a;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         case (lfsr[1:0])
            2'd0: a = A_FLAG;
            2'd1: a = A_SMP;
            2'd2: a = A_RES;
            default: a = A_OTH;
         endcase
         if (lfsr[31:29] == 3'd0) irq_en = lfsr[27:20];
         drive(a, lfsr[2] & lfsr[3], lfsr[4], lfsr[15:8], lfsr[5], lfsr[6],
               lfsr[7] & lfsr[16], lfsr[17] & lfsr[18], lfsr[19]);
         tick("R11 random");
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule